// File: doc/BRIEF.md
# External Interrupt and Event Controller

This block sits between a bank of interrupt sources (pins, peripheral wake lines) and the CPU's interrupt controller. Each configurable line passes through a two-flop synchronizer and an edge detector whose sensitivity is chosen per line: rising, falling, both, or neither. A detected edge, a software trigger or a level retrigger sets the line's pending bit. The pending bit stays set until software writes a 1 to it. Direct lines have a fixed rising edge and no pending storage. Their pulse goes straight through the mask logic.

Every line has two independent masks. One gates the line onto its interrupt output. The other gates its firing onto a single shared CPU event output. Configurable lines 0 to 4 each own an interrupt output. Lines 5 to 9 are ORed onto one group output and lines 10 to 15 onto a second. Configurable lines above 15 have no interrupt output and can only raise CPU events.

For a line marked level-emulated, a write that unmasks its interrupt samples the synchronized pin. If the pin still sits at its active level, the pending bit is set again, so that a level source which was never released fires once more.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: A configurable line sets its pending bit (register address 4, bit = line) on a rising edge when its bit in the rise-enable register (address 0) is 1, and on a falling edge when its bit in the fall-enable register (address 1) is 1. The bit is set on the third rising clock edge after the source changes.
- R3: Writing 1 to a bit of the pending register (address 4) clears that bit. Writing 0 leaves the bit unchanged.
- R4: Writing 1 to a bit of the software-trigger register (address 5) sets that line's pending bit on the same clock edge. Reads of address 5 return zero.
- R5: When a set and a write-1 clear of the same pending bit fall on the same clock edge, the bit ends up set.
- R6: A line's interrupt is raised only while both its pending bit and its interrupt-mask bit (address 2) are 1. A bit that is pending while the line is masked raises the interrupt once the line is unmasked.
- R7: Lines 0 to 4 drive irq_line[0..4]. Lines 5 to 9 are ORed onto irq_grp_a and lines 10 to 15 onto irq_grp_b. Lines 16 and 17 drive no interrupt output.
- R8: Direct line j uses mask bit 18+j in the mask registers. A rising edge on it gives a one-cycle pulse on irq_dir[j] when that mask bit is set, two clock edges after the change. Direct lines never appear in the pending register.
- R9: cpu_event is high in any cycle in which some line fires (an edge, a software trigger, a retrigger, or a direct pulse) and that line's bit in the event-mask register (address 3) is 1.
- R10: For a line whose bit in the level-emulation register (address 6) is 1, a write to address 2 that changes its mask bit from 0 to 1 sets its pending bit if the synchronized pin is at its active level. The active level is high when rise-enable is set, otherwise low when fall-enable is set.
- R11: A line with neither edge enabled never sets its pending bit from its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cfg | input | NCFG | Configurable line sources |
| src_dir | input | NDIR | Direct line sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both write and read |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr, combinational |
| irq_line | output | N_DED | Dedicated interrupts of lines 0..4 |
| irq_grp_a | output | 1 | Shared interrupt of lines 5..9 |
| irq_grp_b | output | 1 | Shared interrupt of lines 10..15 |
| irq_dir | output | NDIR | Masked direct line pulses |
| cpu_event | output | 1 | Shared CPU event |

## Verification
The bench targets the collision of a hardware edge with a write-1 clear in one cycle. A design that lets the clear win loses that event, and the pending bit reads back zero. It checks that a pending bit latched while masked survives until unmask; a design that gates the set with the mask would never raise the interrupt. It covers level emulation with the emulation bit both on and off. A design that retriggers on any unmask shows a spurious pending bit, and one that never samples the pin misses the refire. Event-only lines and direct lines are checked for leaks onto the interrupt outputs and into the pending register.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NCFG  = 18,
  parameter int NDIR  = 4,
  parameter int DW    = 32,
  parameter int N_DED = 5,
  parameter int GA_HI = 9,
  parameter int GB_HI = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCFG-1:0]  src_cfg,
  input  logic [NDIR-1:0]  src_dir,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [N_DED-1:0] irq_line,
  output logic             irq_grp_a,
  output logic             irq_grp_b,
  output logic [NDIR-1:0]  irq_dir,
  output logic             cpu_event
);
  localparam int NL = NCFG + NDIR;
  localparam logic [2:0] A_RISE = 3'd0, A_FALL = 3'd1, A_IMSK = 3'd2, A_EMSK = 3'd3,
                         A_PEND = 3'd4, A_SWT  = 3'd5, A_LVL  = 3'd6;

  logic [NCFG-1:0] c_s1, c_s2, c_prev;
  logic [NDIR-1:0] d_s1, d_s2, d_prev;
  logic [NCFG-1:0] rise, fall, lvl, pend;
  logic [NL-1:0]   imask, emask;

  logic [NCFG-1:0] edge_c, act, retrig, swt, clr, set_v;
  logic [NDIR-1:0] dpulse;
  logic [GB_HI:0]  irq_c;

  wire we_rise = wr_en && addr == A_RISE;
  wire we_fall = wr_en && addr == A_FALL;
  wire we_imsk = wr_en && addr == A_IMSK;
  wire we_emsk = wr_en && addr == A_EMSK;
  wire we_pend = wr_en && addr == A_PEND;
  wire we_swt  = wr_en && addr == A_SWT;
  wire we_lvl  = wr_en && addr == A_LVL;

  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:NL];

  assign edge_c = (rise & c_s2 & ~c_prev) | (fall & ~c_s2 & c_prev);
  assign dpulse = d_s2 & ~d_prev;
  assign act    = (rise & c_s2) | (~rise & fall & ~c_s2);
  assign retrig = we_imsk ? (wdata[NCFG-1:0] & ~imask[NCFG-1:0] & lvl & act) : '0;
  assign swt    = we_swt  ? wdata[NCFG-1:0] : '0;
  assign clr    = we_pend ? wdata[NCFG-1:0] : '0;
  assign set_v  = edge_c | swt | retrig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_s1 <= '0; c_s2 <= '0; c_prev <= '0;
      d_s1 <= '0; d_s2 <= '0; d_prev <= '0;
    end else begin
      c_s1 <= src_cfg; c_s2 <= c_s1; c_prev <= c_s2;
      d_s1 <= src_dir; d_s2 <= d_s1; d_prev <= d_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise <= '0; fall <= '0; lvl <= '0;
      imask <= '0; emask <= '0; pend <= '0;
    end else begin
      if (we_rise) rise  <= wdata[NCFG-1:0];
      if (we_fall) fall  <= wdata[NCFG-1:0];
      if (we_lvl)  lvl   <= wdata[NCFG-1:0];
      if (we_imsk) imask <= wdata[NL-1:0];
      if (we_emsk) emask <= wdata[NL-1:0];
      pend <= (pend & ~clr) | set_v;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RISE: rdata[NCFG-1:0] = rise;
      A_FALL: rdata[NCFG-1:0] = fall;
      A_IMSK: rdata[NL-1:0]   = imask;
      A_EMSK: rdata[NL-1:0]   = emask;
      A_PEND: rdata[NCFG-1:0] = pend;
      A_LVL:  rdata[NCFG-1:0] = lvl;
      default: rdata = '0;
    endcase
  end

  assign irq_c     = pend[GB_HI:0] & imask[GB_HI:0];
  assign irq_line  = irq_c[N_DED-1:0];
  assign irq_grp_a = |irq_c[GA_HI:N_DED];
  assign irq_grp_b = |irq_c[GB_HI:GA_HI+1];
  assign irq_dir   = dpulse & imask[NCFG +: NDIR];
  assign cpu_event = |(set_v & emask[NCFG-1:0]) | |(dpulse & emask[NCFG +: NDIR]);
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NCFG  = 18,
  parameter int NDIR  = 4,
  parameter int DW    = 32,
  parameter int N_DED = 5,
  parameter int GA_HI = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [2:0]           addr,
  input logic [DW-1:0]        wdata,
  input logic [NCFG-1:0]      pend,
  input logic [NCFG-1:0]      set_v,
  input logic [NCFG+NDIR-1:0] imask,
  input logic [NCFG+NDIR-1:0] emask,
  input logic [N_DED-1:0]     irq_line,
  input logic                 irq_grp_a,
  input logic                 cpu_event
);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pend & $past(set_v)) == $past(set_v)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> ((pend & $past(wdata[NCFG-1:0]) & ~$past(set_v)) == '0));

  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != '0) |-> ((irq_line & ~imask[N_DED-1:0]) == '0));

  p_grp_a_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_a |-> (pend[GA_HI:N_DED] != '0));

  p_event_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_event |-> (emask != '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NCFG(NCFG), .NDIR(NDIR), .DW(DW), .N_DED(N_DED), .GA_HI(GA_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pend(pend), .set_v(set_v), .imask(imask), .emask(emask),
  .irq_line(irq_line), .irq_grp_a(irq_grp_a), .cpu_event(cpu_event)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int NCFG = 18, NDIR = 4, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [NCFG-1:0] src_cfg = '0;
  logic [NDIR-1:0] src_dir = '0;
  logic wr_en = 0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [4:0] irq_line;
  logic irq_grp_a, irq_grp_b, cpu_event;
  logic [NDIR-1:0] irq_dir;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .src_cfg(src_cfg), .src_dir(src_dir),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_line(irq_line),
    .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b), .irq_dir(irq_dir), .cpu_event(cpu_event));

  // {rise, fall, start level, end level, expected pending} for line 3
  localparam logic [4:0] VEC [8] = '{5'b10011, 5'b10100, 5'b01101, 5'b01010,
                                     5'b11011, 5'b11101, 5'b00010, 5'b00100};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick(1);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  logic [31:0] r;

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], r);
      chk("R1 reg", r, 0);
    end
    chk("R1 outs", {irq_line, irq_grp_a, irq_grp_b, irq_dir, cpu_event}, 0);
    rst_n = 1;
    tick(1);

    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {31'b0, VEC[i][4]} << 3);
      wr(3'd1, {31'b0, VEC[i][3]} << 3);
      src_cfg[3] = VEC[i][2];
      tick(4);
      wr(3'd4, 32'h8);
      src_cfg[3] = VEC[i][1];
      tick(3);
      rd(3'd4, r);
      chk(VEC[i][4] | VEC[i][3] ? "R2 edge" : "R11 no edge", r[3], VEC[i][0]);
    end
    wr(3'd4, 32'h8);
    wr(3'd0, 0); wr(3'd1, 0);
    src_cfg = '0;
    tick(4);

    // R4 software trigger, R6 latched while masked, R3 clear
    wr(3'd5, 32'h80);
    rd(3'd4, r);
    chk("R4 swtrig sets", r, 32'h80);
    rd(3'd5, r);
    chk("R4 swtrig reads 0", r, 0);
    chk("R6 masked no irq", irq_grp_a, 0);
    wr(3'd2, 32'h80);
    #1 chk("R6 unmask raises", irq_grp_a, 1);
    chk("R7 grp_b idle", irq_grp_b, 0);
    wr(3'd4, 32'h0);
    rd(3'd4, r);
    chk("R3 write 0 keeps", r, 32'h80);
    wr(3'd4, 32'h80);
    rd(3'd4, r);
    chk("R3 clear", r, 0);
    #1 chk("R6 cleared no irq", irq_grp_a, 0);

    // R7 grouping: line 12 -> grp_b, line 16 -> nothing but event
    wr(3'd2, 32'h3_FFFF);
    wr(3'd5, 32'h1000);
    #1 chk("R7 line12 grp_b", {irq_grp_b, irq_grp_a, irq_line}, 7'h40);
    wr(3'd4, 32'h1000);
    wr(3'd3, 32'h1_0000);
    addr = 3'd5; wdata = 32'h1_0000; wr_en = 1; #1;
    chk("R9 event on swtrig", cpu_event, 1);
    tick(1); wr_en = 0; wdata = '0; #1;
    chk("R7 line16 no irq", {irq_grp_b, irq_grp_a, irq_line}, 0);
    chk("R9 event one cycle", cpu_event, 0);
    wr(3'd4, 32'h1_0000);
    wr(3'd5, 32'h2);
    #1 chk("R9 masked no event", cpu_event, 0);
    chk("R7 line1 dedicated", irq_line, 5'h02);
    wr(3'd4, 32'h2);

    // R5 set wins over clear
    wr(3'd0, 32'h4);
    src_cfg[2] = 1;
    tick(2);
    wr(3'd4, 32'h4);
    rd(3'd4, r);
    chk("R5 set wins", r, 32'h4);
    wr(3'd4, 32'h4);
    wr(3'd0, 0);
    src_cfg[2] = 0;
    tick(4);

    // R8 direct line 1 (mask bit 19)
    wr(3'd2, 32'h8_0000);
    wr(3'd3, 32'h8_0000);
    src_dir[1] = 1;
    tick(2);
    chk("R8 direct pulse", irq_dir, 4'b0010);
    chk("R9 direct event", cpu_event, 1);
    tick(1);
    chk("R8 pulse ends", irq_dir, 0);
    rd(3'd4, r);
    chk("R8 no pending", r, 0);
    src_dir[1] = 0;
    tick(3);
    chk("R8 fall ignored", irq_dir, 0);
    wr(3'd3, 0);

    // R10 level emulation on line 4, active high
    wr(3'd0, 32'h10);
    wr(3'd6, 32'h10);
    src_cfg[4] = 1;
    tick(4);
    wr(3'd2, 0);
    wr(3'd4, 32'h10);
    wr(3'd2, 32'h10);
    rd(3'd4, r);
    chk("R10 retrigger", r, 32'h10);
    #1 chk("R10 irq refires", irq_line, 5'h10);
    wr(3'd2, 0);
    wr(3'd4, 32'h10);
    wr(3'd6, 0);
    wr(3'd2, 32'h10);
    rd(3'd4, r);
    chk("R10 off no retrigger", r, 0);
    wr(3'd2, 0);
    wr(3'd6, 32'h10);
    src_cfg[4] = 0;
    tick(4);
    wr(3'd2, 32'h10);
    rd(3'd4, r);
    chk("R10 inactive pin", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule